// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Start Sequencer

This block is the host-side controller that opens an Ultra DMA data-in burst on a parallel ATA-style bus. The local DMA engine holds `startEn` high while it wants a transfer. The block waits for the device's request line. It then moves the host's control lines into the burst posture: STOP asserted, host-ready negated, chip selects and address negated. It waits a mode-dependent settle interval and grants acknowledge. On the following cycle it turns the 16-bit data bus around. It then watches the device take over the strobe.

The request and strobe inputs are asynchronous and pass through a two-flop synchroniser before the sequencer sees them. All intervals are whole clock cycles, derived when the block is elaborated from the clock period and the mode-dependent recipient setup and hold figures. The block reports a protocol error if the device drops its request too early or moves the strobe inside the forbidden window after acknowledge. `burstActive` rises once the first valid falling strobe edge has been seen.

While idle, with acknowledge negated on the previous cycle as well, the PIO chip-select and address inputs pass straight through to the bus.

Top module: `udma_init_seq`

## Requirements
- R1: After reset and while idle, `ackNOut`=1, `stopOut`=0, `hostRdyOut`=0, `burstActive`=0, `protoErr`=0 and `dataOeOut`=1. Also in idle, `csNOut`/`addrOut` equal `pioCsN`/`pioAddr` whenever `ackNOut` was 1 on the previous cycle.
- R2: No burst starts unless `startEn` and the synchronised `devReq` are both high. Either one alone leaves `stopOut` at 0.
- R3: Three rising clock edges after `devReq` and `startEn` are both applied, the preparation values appear together: `stopOut`=1, `hostRdyOut`=0, `csNOut`=2'b11 and `addrOut`=3'b000. Acknowledge never asserts unless STOP was asserted on the cycle before.
- R4: While `ackNOut`=0, and on the first cycle after it returns to 1, `csNOut` stays 2'b11 and `addrOut` stays 3'b000.
- R5: `ackNOut` falls exactly tAck+1 rising edges after the preparation values appear. Here tAck = ceil((ACK_BASE_PS + setup(mode)) / CLK_PS). The setup values in ps are 14700, 9700, 6800, 6800, 4800, 2300 and 2300 for modes 0 to 6, and mode 7 uses the mode 6 value. Once asserted, acknowledge stays asserted until `startEn` falls or an error occurs.
- R6: `dataOeOut` is still 1 in the first cycle of acknowledge and is 0 from the next cycle on.
- R7: The takeover window is tZ = ceil((ZIO_BASE_PS + hold(mode)) / CLK_PS) cycles after acknowledge. The hold value is 4800 ps in modes 0 to 4 and 2800 ps in modes 5 to 7. If a synchronised strobe edge arrives before the window opens, or before acknowledge, the block sets `protoErr` and returns to idle with `ackNOut`=1.
- R8: The first synchronised falling strobe edge after the window opens makes `burstActive`=1, `hostRdyOut`=1 and `stopOut`=0, with acknowledge held.
- R9: If the synchronised request falls after the burst has started but before the first valid falling strobe edge, the block sets `protoErr` and returns to idle. `protoErr` stays set until reset. A request drop once `burstActive`=1 raises no error.
- R10: `startEn` low returns the block to idle on the next edge from any state, and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startEn | input | 1 | Transfer enable from the local DMA engine |
| devReq | input | 1 | Device DMA request, asynchronous |
| devStrobe | input | 1 | Device strobe, asynchronous |
| modeSel | input | 3 | Ultra DMA mode 0 to 7 (7 treated as 6) |
| pioCsN | input | 2 | PIO chip selects, active low, passed through while idle |
| pioAddr | input | 3 | PIO register address, passed through while idle |
| stopOut | output | 1 | STOP line, 1 = asserted |
| hostRdyOut | output | 1 | Host ready line, 1 = asserted |
| csNOut | output | 2 | Chip selects to the bus, active low |
| addrOut | output | 3 | Address lines to the bus |
| ackNOut | output | 1 | DMA acknowledge, active low |
| dataOeOut | output | 1 | Host data bus output enable |
| burstActive | output | 1 | Burst under way after the first valid strobe fall |
| protoErr | output | 1 | Sticky protocol error flag |

## Verification
The bench builds the block with CLK_PS=5000 rather than the 20000 default. At that setting the acknowledge intervals differ by mode: 7, 6, 6, 6, 5, 5, 5 and 5 cycles for modes 0 to 7. This brings the per-mode lookup, and the mode 7 fold onto mode 6, within reach of an exact cycle-count check. The takeover window is then 5 cycles in every mode. That is wide enough to place a strobe edge clearly inside it and clearly after it, so both the early-edge error and the normal start are exercised.

// File: rtl/udma_init_pkg.sv
package udma_init_pkg;

  localparam int MODE_W = 3;

  // one-hot sequencer states
  typedef enum logic [5:0] {
    ST_IDLE     = 6'b000001,
    ST_PREP     = 6'b000010,
    ST_WAIT_ACK = 6'b000100,
    ST_ACK_TURN = 6'b001000,
    ST_WAIT_STB = 6'b010000,
    ST_ACTIVE   = 6'b100000
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadAck;
    logic loadWin;
    logic passPio;
  } ctlStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic reqHigh;
    logic strEdge;
    logic strFall;
    logic ackDone;
    logic winOpen;
  } dpStat_t;

  // recipient setup per mode, picoseconds
  function automatic int setupPs(input int mode);
    case (mode)
      0:       return 14700;
      1:       return 9700;
      2, 3:    return 6800;
      4:       return 4800;
      default: return 2300;
    endcase
  endfunction

  // recipient hold per mode, picoseconds
  function automatic int holdPs(input int mode);
    return (mode <= 4) ? 4800 : 2800;
  endfunction

  function automatic int ceilCycles(input int ps, input int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/udma_init_dpath.sv
module udma_init_dpath
  import udma_init_pkg::*;
#(
  parameter int CLK_PS      = 20000,
  parameter int ACK_BASE_PS = 20000,
  parameter int ZIO_BASE_PS = 20000,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              devReq,
  input  logic              devStrobe,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [1:0]        pioCsN,
  input  logic [2:0]        pioAddr,
  input  ctlStrb_t          strb,
  input  logic              ackNIn,
  output dpStat_t           stat,
  output logic [1:0]        csNOut,
  output logic [2:0]        addrOut
);

  localparam int NUM_SEL = 1 << MODE_W;
  localparam int TOP_MODE = 6;

  // per-mode cycle counts, computed at elaboration
  logic [CNT_W-1:0] ackTab [NUM_SEL];
  logic [CNT_W-1:0] winTab [NUM_SEL];

  for (genvar m = 0; m < NUM_SEL; m++) begin : g_mode
    localparam int EFF = (m > TOP_MODE) ? TOP_MODE : m;
    localparam int ACK_C = ceilCycles(ACK_BASE_PS + setupPs(EFF), CLK_PS);
    localparam int WIN_C = ceilCycles(ZIO_BASE_PS + holdPs(EFF), CLK_PS);
    assign ackTab[m] = CNT_W'(ACK_C);
    assign winTab[m] = CNT_W'(WIN_C);
  end

  // synchronisers
  logic [1:0] rawIn, syncOut;
  assign rawIn = {devStrobe, devReq};

  udma_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (rawIn),
    .q   (syncOut)
  );

  logic strPrev;
  always_ff @(posedge clk) begin
    if (rst) strPrev <= 1'b0;
    else     strPrev <= syncOut[1];
  end

  // interval counters
  logic [CNT_W-1:0] ackCnt, winCnt;

  always_ff @(posedge clk) begin
    if (rst)                ackCnt <= '0;
    else if (strb.loadAck)  ackCnt <= ackTab[modeSel];
    else if (ackCnt != '0)  ackCnt <= ackCnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                winCnt <= '0;
    else if (strb.loadWin)  winCnt <= winTab[modeSel];
    else if (winCnt != '0)  winCnt <= winCnt - CNT_W'(1);
  end

  assign stat.reqHigh = syncOut[0];
  assign stat.strEdge = syncOut[1] ^ strPrev;
  assign stat.strFall = strPrev & ~syncOut[1];
  assign stat.ackDone = (ackCnt == '0);
  assign stat.winOpen = (winCnt == '0);

  // select/address hold one cycle past acknowledge release
  logic ackNq;
  always_ff @(posedge clk) begin
    if (rst) ackNq <= 1'b1;
    else     ackNq <= ackNIn;
  end

  logic pioPass;
  assign pioPass = strb.passPio & ackNq & ackNIn;
  assign csNOut  = pioPass ? pioCsN  : 2'b11;
  assign addrOut = pioPass ? pioAddr : 3'b000;

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(ackNIn) |-> (csNOut == 2'b11 && addrOut == 3'b000)); // R4

endmodule

// File: rtl/udma_init_ctrl.sv
module udma_init_ctrl
  import udma_init_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     startEn,
  input  dpStat_t  stat,
  output ctlStrb_t strb,
  output logic     stopOut,
  output logic     hostRdyOut,
  output logic     ackNOut,
  output logic     dataOeOut,
  output logic     burstActive,
  output logic     protoErr
);

  seqState_t curSt, nxtSt;
  logic      errSet, errQ;

  always_comb begin
    nxtSt  = curSt;
    errSet = 1'b0;
    unique case (curSt)
      ST_IDLE: begin
        if (startEn && stat.reqHigh) nxtSt = ST_PREP;
      end
      ST_PREP: begin
        if (!startEn)                  nxtSt = ST_IDLE;
        else if (!stat.reqHigh || stat.strEdge) begin
          errSet = 1'b1; nxtSt = ST_IDLE;
        end else                       nxtSt = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        if (!startEn)                  nxtSt = ST_IDLE;
        else if (!stat.reqHigh || stat.strEdge) begin
          errSet = 1'b1; nxtSt = ST_IDLE;
        end else if (stat.ackDone)     nxtSt = ST_ACK_TURN;
      end
      ST_ACK_TURN: begin
        if (!startEn)                  nxtSt = ST_IDLE;
        else if (!stat.reqHigh || (stat.strEdge && !stat.winOpen)) begin
          errSet = 1'b1; nxtSt = ST_IDLE;
        end else                       nxtSt = ST_WAIT_STB;
      end
      ST_WAIT_STB: begin
        if (!startEn)                  nxtSt = ST_IDLE;
        else if (stat.strEdge && !stat.winOpen) begin
          errSet = 1'b1; nxtSt = ST_IDLE;
        end else if (stat.strFall)     nxtSt = ST_ACTIVE;
        else if (!stat.reqHigh) begin
          errSet = 1'b1; nxtSt = ST_IDLE;
        end
      end
      ST_ACTIVE: begin
        if (!startEn)                  nxtSt = ST_IDLE;
      end
      default: nxtSt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curSt <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      curSt <= nxtSt;
      if (errSet) errQ <= 1'b1;
    end
  end

  assign strb.loadAck = (curSt == ST_IDLE) && (nxtSt == ST_PREP);
  assign strb.loadWin = (curSt == ST_WAIT_ACK) && (nxtSt == ST_ACK_TURN);
  assign strb.passPio = (curSt == ST_IDLE);

  assign stopOut     = curSt inside {ST_PREP, ST_WAIT_ACK, ST_ACK_TURN, ST_WAIT_STB};
  assign hostRdyOut  = (curSt == ST_ACTIVE);
  assign ackNOut     = !(curSt inside {ST_ACK_TURN, ST_WAIT_STB, ST_ACTIVE});
  assign dataOeOut   = curSt inside {ST_IDLE, ST_PREP, ST_WAIT_ACK, ST_ACK_TURN};
  assign burstActive = (curSt == ST_ACTIVE);
  assign protoErr    = errQ;

  AST_ACK_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $fell(ackNOut) |-> $past(stopOut)); // R3
  AST_ACK_INTERVAL: assert property (@(posedge clk) disable iff (rst)
    $fell(ackNOut) |-> $past(stat.ackDone)); // R5
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!ackNOut && $past(!ackNOut)) |-> !dataOeOut); // R6
  AST_ACTIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(burstActive) |-> ($past(stat.winOpen) && $past(stat.strFall))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(protoErr) |-> protoErr); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(!startEn) |-> (ackNOut && !stopOut)); // R10

endmodule

// File: rtl/udma_init_seq.sv
module udma_init_seq
  import udma_init_pkg::*;
#(
  parameter int CLK_PS      = 20000,
  parameter int ACK_BASE_PS = 20000,
  parameter int ZIO_BASE_PS = 20000,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startEn,
  input  logic       devReq,
  input  logic       devStrobe,
  input  logic [2:0] modeSel,
  input  logic [1:0] pioCsN,
  input  logic [2:0] pioAddr,
  output logic       stopOut,
  output logic       hostRdyOut,
  output logic [1:0] csNOut,
  output logic [2:0] addrOut,
  output logic       ackNOut,
  output logic       dataOeOut,
  output logic       burstActive,
  output logic       protoErr
);

  ctlStrb_t strb;
  dpStat_t  stat;

  udma_init_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .startEn     (startEn),
    .stat        (stat),
    .strb        (strb),
    .stopOut     (stopOut),
    .hostRdyOut  (hostRdyOut),
    .ackNOut     (ackNOut),
    .dataOeOut   (dataOeOut),
    .burstActive (burstActive),
    .protoErr    (protoErr)
  );

  udma_init_dpath #(
    .CLK_PS      (CLK_PS),
    .ACK_BASE_PS (ACK_BASE_PS),
    .ZIO_BASE_PS (ZIO_BASE_PS),
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .devReq    (devReq),
    .devStrobe (devStrobe),
    .modeSel   (modeSel),
    .pioCsN    (pioCsN),
    .pioAddr   (pioAddr),
    .strb      (strb),
    .ackNIn    (ackNOut),
    .stat      (stat),
    .csNOut    (csNOut),
    .addrOut   (addrOut)
  );

endmodule

// File: tb/udma_init_seq_tb.sv
`timescale 1ns/1ps
module udma_init_seq_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startEn = 1'b0, devReq = 1'b0, devStrobe = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [1:0] pioCsN = 2'b11;
  logic [2:0] pioAddr = 3'b000;
  logic stopOut, hostRdyOut, ackNOut, dataOeOut, burstActive, protoErr;
  logic [1:0] csNOut;
  logic [2:0] addrOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  udma_init_seq #(.CLK_PS(5000)) dut_i (
    .clk(clk), .rst(rst), .startEn(startEn), .devReq(devReq),
    .devStrobe(devStrobe), .modeSel(modeSel), .pioCsN(pioCsN),
    .pioAddr(pioAddr), .stopOut(stopOut), .hostRdyOut(hostRdyOut),
    .csNOut(csNOut), .addrOut(addrOut), .ackNOut(ackNOut),
    .dataOeOut(dataOeOut), .burstActive(burstActive), .protoErr(protoErr)
  );

  // mode, expected acknowledge interval, expected takeover window
  localparam int NVEC = 8;
  localparam int VEC_ACK [NVEC] = '{7, 6, 6, 6, 5, 5, 5, 5};
  localparam int VEC_WIN [NVEC] = '{5, 5, 5, 5, 5, 5, 5, 5};

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    startEn = 1'b0; devReq = 1'b0; devStrobe = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic startBurst(output int n);
    startEn = 1'b1; devReq = 1'b1;
    n = 0;
    while (!stopOut && n < 20) begin @(negedge clk); n++; end
  endtask

  task automatic waitAck(output int c);
    c = 0;
    while (ackNOut && c < 40) begin @(negedge clk); c++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int n, c, w;
    @(negedge clk);
    doReset();

    // R1 reset and idle state
    pioCsN = 2'b01; pioAddr = 3'b101;
    @(negedge clk);
    chk("R1 ackN", ackNOut, 1);
    chk("R1 stop", stopOut, 0);
    chk("R1 hostRdy", hostRdyOut, 0);
    chk("R1 burstActive", burstActive, 0);
    chk("R1 protoErr", protoErr, 0);
    chk("R1 dataOe", dataOeOut, 1);
    chk("R1 cs pass", csNOut, 2'b01);
    chk("R1 addr pass", addrOut, 3'b101);

    // R2 neither input alone starts a burst
    startEn = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 startEn only", stopOut, 0);
    startEn = 1'b0; devReq = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 devReq only", stopOut, 0);
    devReq = 1'b0;
    repeat (4) @(negedge clk);

    // table walk over every mode
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      modeSel = 3'(i);
      pioCsN = 2'b00; pioAddr = 3'b110;
      startBurst(n);
      chk("R3 prep delay", n, 3);
      chk("R3 prep hostRdy", hostRdyOut, 0);
      chk("R3 prep cs", csNOut, 2'b11);
      chk("R3 prep addr", addrOut, 3'b000);
      waitAck(c);
      chk("R5 ack interval", c, VEC_ACK[i] + 1);
      chk("R6 oe in first ack cycle", dataOeOut, 1);
      @(negedge clk);
      chk("R6 oe released", dataOeOut, 0);
      chk("R4 cs during ack", csNOut, 2'b11);
      repeat (VEC_WIN[i] + 2) @(negedge clk);
      devStrobe = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7 late rise no error", protoErr, 0);
      devStrobe = 1'b0;
      w = 0;
      while (!burstActive && w < 10) begin @(negedge clk); w++; end
      chk("R8 burstActive", burstActive, 1);
      chk("R8 hostRdy", hostRdyOut, 1);
      chk("R8 stop", stopOut, 0);
      chk("R8 ack held", ackNOut, 0);
      devReq = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 late req drop ok", protoErr, 0);
      chk("R9 still active", burstActive, 1);
      startEn = 1'b0;
      @(negedge clk);
      chk("R10 ack released", ackNOut, 1);
      chk("R4 cs held after ack", csNOut, 2'b11);
      @(negedge clk);
      chk("R1 cs pass after", csNOut, 2'b00);
      chk("R10 no error", protoErr, 0);
    end

    // R9 request drop while waiting for acknowledge
    doReset();
    modeSel = 3'd0;
    startBurst(n);
    devReq = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 early drop err", protoErr, 1);
    chk("R9 ack negated", ackNOut, 1);
    chk("R9 stop dropped", stopOut, 0);
    repeat (5) @(negedge clk);
    chk("R9 err sticky", protoErr, 1);

    // R7 strobe moved inside the forbidden window
    doReset();
    modeSel = 3'd0;
    startBurst(n);
    waitAck(c);
    devStrobe = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 early strobe err", protoErr, 1);
    chk("R7 ack negated", ackNOut, 1);
    chk("R7 no burst", burstActive, 0);

    // R10 abort before acknowledge
    doReset();
    modeSel = 3'd4;
    startBurst(n);
    @(negedge clk);
    startEn = 1'b0;
    @(negedge clk);
    chk("R10 abort stop", stopOut, 0);
    chk("R10 abort ackN", ackNOut, 1);
    chk("R10 abort no error", protoErr, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule